// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Bits

This block holds the per-vector message table and the pending-bit array of one PCI function that signals interrupts by memory writes. Software reaches both regions over a small register bus, in 4-byte or 8-byte units. Separately, the block holds the function-wide mask and enable flags of the capability's control word. Device logic raises one request line per vector. A request that arrives while the vector can fire becomes a message (a 64-bit address and a 32-bit data word taken from the vector's table slot), presented on a valid/ready output.

A request that arrives while the function or the vector is masked is recorded as a pending bit and is not lost. When the function mask drops, the pending vectors are replayed. When a table write unmasks an individual vector, its pending message is replayed too. When several messages are due together, they leave one per cycle, lowest vector first. A pending bit clears only when its message has been accepted downstream.

Top module: `msgint_vector_ctrl`

## Requirements
- R1: After reset, every vector-control word reads 1, all pending bits read 0, and the control word reads enable=0 and function mask=0.
- R2: Each vector owns 16 bytes at byte offset 16*v. The dwords are: byte +0 address low, +4 address high, +8 message data, +12 vector control. A 4-byte access reaches the dword at offset bits [3:2]. An 8-byte access at +0 or +8 reaches two dwords, with the lower-addressed dword in bits [31:0].
- R3: An access is ignored and reads 0 if any of the following holds: its length is not 4 or 8, it is an 8-byte access with offset bit 2 set, or it targets a vector index at or above the vector count.
- R4: The control word carries the enable in bit 15, the function mask in bit 14, zero in bits 13:11, and the vector count minus one in bits 10:0. A write to it changes only bits 15 and 14.
- R5: A vector is masked exactly when bit 0 of its control dword is 1. The other bits of that dword have no effect on masking.
- R6: When enabled, a request for an unmasked vector of an unmasked function produces one message. The message carries address {high,low}, the data dword and the vector index.
- R7: A request while the function mask or the vector mask is set sends nothing and sets the vector's pending bit. Pending bit n sits at bit n%64 of the 8-byte pending word n/64. A 4-byte read at offset bit 2 = 1 returns the upper half of that word. The pending region is read-only and ignores writes.
- R8: When a control write takes the function mask from 1 to 0, every pending vector whose own mask is clear is sent, and its pending bit clears.
- R9: When a table write takes a vector's mask bit from 1 to 0 while the function mask is 0 and the vector is pending, its message is sent and its pending bit clears.
- R10: Messages due at the same time leave one per cycle in ascending vector order under a valid/ready handshake. A pending bit clears only in the cycle its message is accepted.
- R11: While enable is 0, no message is offered and requests change no state.
- R12: A message that is due but not yet accepted is withdrawn when its vector or the function becomes masked. Its pending bit is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_pba | input | 1 | 1 = pending-bit region, 0 = vector table region |
| bus_addr | input | ADDR_W | Byte offset within the selected region |
| bus_len | input | 4 | Access length in bytes (4 or 8) |
| bus_wdata | input | 64 | Write data, lower dword in bits 31:0 |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 64 | Read data |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | 16 | Control-word write value |
| ctl_rdata | output | 16 | Current control word |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The message is accepted this cycle |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |
| msg_vec | output | VEC_W | Index of the offered vector |

## Verification
The bench builds the block with its defaults: eight vectors and a 12-bit offset. With eight vectors, every vector can be given its own table contents and its own request. The whole pending array then fits in one pending word, so each test is a single read compared with a bit pattern computed in the bench. The small count lets the bench sweep all vectors through table access, direct sends and pending replay, and check the full ascending drain order under a stalled consumer. The bench also reaches the out-of-range index at exactly the vector count.

// File: rtl/msgint_pkg.sv
`timescale 1ns/1ps
package msgint_pkg;

  localparam int unsigned DWORDS_PER_VEC = 4;
  localparam int unsigned DW_VCTL        = 3;
  localparam int unsigned BITS_PER_PWORD = 64;

  // byte offset -> vector slot (16 bytes per slot)
  function automatic logic [31:0] slot_of(input logic [31:0] off);
    return off >> 4;
  endfunction

  // byte offset -> dword within slot
  function automatic logic [1:0] dword_of(input logic [31:0] off);
    return off[3:2];
  endfunction

  // byte offset -> 8-byte pending word
  function automatic logic [31:0] pword_of(input logic [31:0] off);
    return off >> 3;
  endfunction

  function automatic logic len_legal(input logic [3:0] len);
    return (len == 4'd4) || (len == 4'd8);
  endfunction

  // 8-byte accesses must start on an 8-byte boundary
  function automatic logic align_legal(input logic [3:0] len, input logic [31:0] off);
    return (len == 4'd4) || !off[2];
  endfunction

  function automatic logic [15:0] ctl_word(input logic en, input logic fmask,
                                           input int unsigned nvec);
    logic [10:0] sz;
    sz = 11'(nvec - 1);
    return {en, fmask, 3'b000, sz};
  endfunction

endpackage

// File: rtl/msgint_table.sv
`timescale 1ns/1ps
module msgint_table
  import msgint_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 12,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int PWORDS = (NUM_VEC + 63) / 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_pba,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_len,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  input  logic [NUM_VEC-1:0] pend,
  input  logic [VEC_W-1:0]  sel_vec,
  output logic [63:0]       sel_addr,
  output logic [31:0]       sel_data,
  output logic [NUM_VEC-1:0] emask,
  output logic [NUM_VEC-1:0] ent_unmask
);

  logic [31:0] ent_q [NUM_VEC][DWORDS_PER_VEC];

  logic [31:0] off;
  logic [31:0] slot;
  logic [31:0] pword;
  logic [1:0]  dsel;
  logic        len8;
  logic        tbl_ok;
  logic        pba_ok;
  logic        wr_tbl;
  logic [VEC_W-1:0] eidx;
  logic [DWORDS_PER_VEC-1:0] lane_we;
  logic [31:0] lane_dat [DWORDS_PER_VEC];
  logic [PWORDS*BITS_PER_PWORD-1:0] pend_pad;
  logic [63:0] rd_word;

  assign off    = 32'(bus_addr);
  assign slot   = slot_of(off);
  assign pword  = pword_of(off);
  assign dsel   = dword_of(off);
  assign len8   = (bus_len == 4'd8);
  assign tbl_ok = len_legal(bus_len) && align_legal(bus_len, off) && (slot < 32'(NUM_VEC));
  assign pba_ok = len_legal(bus_len) && align_legal(bus_len, off) && (pword < 32'(PWORDS));
  assign eidx   = VEC_W'(slot);
  assign wr_tbl = bus_valid && bus_write && !bus_pba && tbl_ok;
  assign pend_pad = (PWORDS*BITS_PER_PWORD)'(pend);

  // lane decode: dword dsel always, dsel+1 as well for 8-byte access
  always_comb begin
    for (int dw = 0; dw < int'(DWORDS_PER_VEC); dw++) begin
      lane_we[dw]  = (2'(dw) == dsel) || (len8 && (2'(dw) == (dsel | 2'b01)));
      lane_dat[dw] = (len8 && dw[0]) ? bus_wdata[63:32] : bus_wdata[31:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_VEC; e++)
        for (int dw = 0; dw < int'(DWORDS_PER_VEC); dw++)
          ent_q[e][dw] <= (dw == int'(DW_VCTL)) ? 32'd1 : 32'd0;
    end else if (wr_tbl) begin
      for (int dw = 0; dw < int'(DWORDS_PER_VEC); dw++)
        if (lane_we[dw]) ent_q[eidx][dw] <= lane_dat[dw];
    end
  end

  always_comb begin
    for (int e = 0; e < NUM_VEC; e++) begin
      emask[e]      = ent_q[e][DW_VCTL][0];
      ent_unmask[e] = wr_tbl && (eidx == VEC_W'(e)) && lane_we[DW_VCTL]
                      && ent_q[e][DW_VCTL][0] && !lane_dat[DW_VCTL][0];
    end
  end

  always_comb begin
    logic [63:0] pw;
    rd_word = '0;
    pw      = '0;
    if (!bus_pba) begin
      if (tbl_ok) begin
        if (len8) rd_word = {ent_q[eidx][dsel | 2'b01], ent_q[eidx][dsel]};
        else      rd_word = {32'd0, ent_q[eidx][dsel]};
      end
    end else if (pba_ok) begin
      pw = pend_pad[pword*BITS_PER_PWORD +: 64];
      if (len8)        rd_word = pw;
      else if (off[2]) rd_word = {32'd0, pw[63:32]};
      else             rd_word = {32'd0, pw[31:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_word;
    end
  end

  assign sel_addr = {ent_q[sel_vec][1], ent_q[sel_vec][0]};
  assign sel_data = ent_q[sel_vec][2];

endmodule

// File: rtl/msgint_pend.sv
`timescale 1ns/1ps
module msgint_pend #(
  parameter int NUM_VEC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic               en,
  input  logic               fmask,
  input  logic [NUM_VEC-1:0] emask,
  input  logic               fn_unmask,
  input  logic [NUM_VEC-1:0] ent_unmask,
  input  logic [NUM_VEC-1:0] accept,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] arm
);

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic masked;
    logic pend_n;
    logic arm_n;

    assign masked = fmask || emask[v];

    always_comb begin
      pend_n = pend[v];
      arm_n  = arm[v];
      if (accept[v]) begin
        pend_n = 1'b0;
        arm_n  = 1'b0;
      end
      // due but masked again: fall back to pending
      if (arm[v] && masked) begin
        arm_n  = 1'b0;
        pend_n = 1'b1;
      end
      if (en && irq_req[v]) begin
        if (masked) pend_n = 1'b1;
        else        arm_n  = 1'b1;
      end
      if (fn_unmask && !emask[v] && pend_n) arm_n = 1'b1;
      if (ent_unmask[v] && !fmask && pend_n) arm_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[v] <= 1'b0;
        arm[v]  <= 1'b0;
      end else begin
        pend[v] <= pend_n;
        arm[v]  <= arm_n;
      end
    end
  end

endmodule

// File: rtl/msgint_arb.sv
`timescale 1ns/1ps
module msgint_arb #(
  parameter int NUM_VEC = 8,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic [NUM_VEC-1:0] req,
  output logic [NUM_VEC-1:0] grant,
  output logic [VEC_W-1:0]   gvec,
  output logic               any
);

  assign any   = |req;
  assign grant = req & (~req + NUM_VEC'(1));

  always_comb begin
    gvec = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (req[v]) gvec = VEC_W'(v);
  end

endmodule

// File: rtl/msgint_vector_ctrl.sv
`timescale 1ns/1ps
module msgint_vector_ctrl
  import msgint_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int ADDR_W  = 12,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_pba,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [3:0]         bus_len,
  input  logic [63:0]        bus_wdata,
  output logic               bus_rvalid,
  output logic [63:0]        bus_rdata,
  input  logic               ctl_we,
  input  logic [15:0]        ctl_wdata,
  output logic [15:0]        ctl_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  output logic [VEC_W-1:0]   msg_vec
);

  logic               en_q;
  logic               fmask_q;
  logic               fn_unmask;
  logic [NUM_VEC-1:0] emask;
  logic [NUM_VEC-1:0] ent_unmask;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] arm;
  logic [NUM_VEC-1:0] sendable;
  logic [NUM_VEC-1:0] grant;
  logic [NUM_VEC-1:0] accept;
  logic               any_due;

  // control word: only enable and function mask are writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      fmask_q <= 1'b0;
    end else if (ctl_we) begin
      en_q    <= ctl_wdata[15];
      fmask_q <= ctl_wdata[14];
    end
  end

  assign fn_unmask = ctl_we && fmask_q && !ctl_wdata[14];
  assign ctl_rdata = ctl_word(en_q, fmask_q, NUM_VEC);

  msgint_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_pba(bus_pba),
    .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .pend(pend), .sel_vec(msg_vec),
    .sel_addr(msg_addr), .sel_data(msg_data),
    .emask(emask), .ent_unmask(ent_unmask)
  );

  msgint_pend #(.NUM_VEC(NUM_VEC)) pend_i (
    .clk(clk), .rst_n(rst_n),
    .irq_req(irq_req), .en(en_q), .fmask(fmask_q), .emask(emask),
    .fn_unmask(fn_unmask), .ent_unmask(ent_unmask), .accept(accept),
    .pend(pend), .arm(arm)
  );

  assign sendable = arm & ~emask & {NUM_VEC{!fmask_q}};

  msgint_arb #(.NUM_VEC(NUM_VEC)) arb_i (
    .req(sendable), .grant(grant), .gvec(msg_vec), .any(any_due)
  );

  assign msg_valid = en_q && any_due;
  assign accept    = grant & {NUM_VEC{msg_valid && msg_ready}};

endmodule

// File: rtl/msgint_vector_ctrl_chk.sv
`timescale 1ns/1ps
module msgint_vector_ctrl_chk #(
  parameter int NUM_VEC = 8,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_q,
  input logic               fmask_q,
  input logic [NUM_VEC-1:0] emask,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] arm,
  input logic [NUM_VEC-1:0] accept,
  input logic [NUM_VEC-1:0] irq_req,
  input logic               msg_valid,
  input logic [VEC_W-1:0]   msg_vec
);

  logic [NUM_VEC-1:0] blocked;
  logic [NUM_VEC-1:0] below;
  assign blocked = emask | {NUM_VEC{fmask_q}};
  assign below   = (NUM_VEC'(1) << msg_vec) - NUM_VEC'(1);

  p_quiet_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !msg_valid);

  p_offer_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (!fmask_q && !emask[msg_vec]));

  p_masked_req_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && ((irq_req & blocked) != '0)) |=>
      ((pend & $past(irq_req & blocked)) == $past(irq_req & blocked)));

  p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((arm & ~emask & below) == '0));

  p_clear_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(pend) & ~pend) & ~$past(accept)) == '0));

endmodule

bind msgint_vector_ctrl msgint_vector_ctrl_chk #(.NUM_VEC(NUM_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .fmask_q(fmask_q), .emask(emask),
  .pend(pend), .arm(arm), .accept(accept), .irq_req(irq_req),
  .msg_valid(msg_valid), .msg_vec(msg_vec)
);

// File: tb/msgint_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module msgint_vector_ctrl_tb_top;

  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_pba = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_len = 4'd4;
  logic [63:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [63:0] bus_rdata;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic [NV-1:0] irq_req = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [2:0]  msg_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [2:0]  lg_vec  [256];
  logic [63:0] lg_addr [256];
  logic [31:0] lg_data [256];
  int lg_n = 0;

  always #2.5 clk = ~clk;

  msgint_vector_ctrl #(.NUM_VEC(NV), .ADDR_W(12)) dut_i (.*);

  // log accepted messages, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && msg_valid && msg_ready && lg_n < 256) begin
      lg_vec[lg_n]  = msg_vec;
      lg_addr[lg_n] = msg_addr;
      lg_data[lg_n] = msg_data;
      lg_n++;
    end
  end

  function automatic logic [63:0] x_addr(int e);
    return {32'h0000_00B0 + 32'(e), 32'hA000_0000 + 32'(e * 16)};
  endfunction
  function automatic logic [31:0] x_data(int e);
    return 32'h0000_D000 + 32'(e);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic pba, input int off, input int len, input logic [63:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_pba = pba;
    bus_addr = 12'(off); bus_len = 4'(len); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic pba, input int off, input int len, output logic [63:0] r);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_pba = pba;
    bus_addr = 12'(off); bus_len = 4'(len);
    @(negedge clk);
    r = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic ctl_wr(input logic [15:0] d);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic pulse(input logic [NV-1:0] m);
    @(negedge clk);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_msg(input string tag, input int idx, input int e);
    chk({tag, " vec"}, 64'(lg_vec[idx]), 64'(e));
    chk({tag, " addr"}, lg_addr[idx], x_addr(e));
    chk({tag, " data"}, 64'(lg_data[idx]), 64'(x_data(e)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    int base;
    int k;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int e = 0; e < NV; e++) begin
      bus_rd(0, e * 16 + 12, 4, r);
      chk("R1 vctl reset", r, 64'd1);
    end
    bus_rd(1, 0, 8, r);
    chk("R1 pending reset", r, 64'd0);
    chk("R1 R4 ctl reset", 64'(ctl_rdata), 64'h0007);

    // R2 layout, both widths
    for (int e = 0; e < NV; e++) begin
      bus_wr(0, e * 16, 8, x_addr(e));
      bus_wr(0, e * 16 + 8, 4, 64'(x_data(e)));
    end
    for (int e = 0; e < NV; e++) begin
      bus_rd(0, e * 16, 8, r);
      chk("R2 addr pair", r, x_addr(e));
      bus_rd(0, e * 16 + 4, 4, r);
      chk("R2 addr high", r, {32'd0, x_addr(e)[63:32]});
      bus_rd(0, e * 16 + 8, 8, r);
      chk("R2 data+vctl", r, {32'd1, x_data(e)});
    end

    // R3 illegal accesses
    bus_wr(0, 8, 2, 64'h1234);
    bus_rd(0, 8, 4, r);
    chk("R3 len2 write ignored", r, 64'(x_data(0)));
    bus_rd(0, 8, 2, r);
    chk("R3 len2 read zero", r, 64'd0);
    bus_rd(0, 4, 8, r);
    chk("R3 misaligned read zero", r, 64'd0);
    bus_wr(0, 4, 8, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(0, 0, 8, r);
    chk("R3 misaligned write ignored", r, x_addr(0));
    bus_rd(0, NV * 16, 4, r);
    chk("R3 out of range read", r, 64'd0);

    // R4 control word
    ctl_wr(16'hFFFF);
    chk("R4 ctl all ones", 64'(ctl_rdata), 64'hC007);
    ctl_wr(16'h0000);
    chk("R4 ctl cleared", 64'(ctl_rdata), 64'h0007);

    // R11 disabled: unmask all, requests ignored
    for (int e = 0; e < NV; e++) bus_wr(0, e * 16 + 12, 4, 64'd0);
    pulse('1);
    idle(4);
    chk("R11 no message while disabled", 64'(lg_n), 64'd0);
    bus_rd(1, 0, 8, r);
    chk("R11 no pending while disabled", r, 64'd0);

    // R6 enable and sweep each vector
    ctl_wr(16'h8000);
    for (int e = 0; e < NV; e++) begin
      base = lg_n;
      pulse(NV'(1) << e);
      idle(4);
      chk("R6 one message", 64'(lg_n - base), 64'd1);
      chk_msg("R6", base, e);
    end

    // R5 only bit 0 masks
    bus_wr(0, 2 * 16 + 8, 8, {32'hFFFF_FFFE, x_data(2)});
    base = lg_n;
    pulse(8'h04);
    idle(4);
    chk("R5 upper vctl bits ignored", 64'(lg_n - base), 64'd1);
    bus_wr(0, 2 * 16 + 12, 4, 64'd1);
    base = lg_n;
    pulse(8'h04);
    idle(4);
    chk("R7 masked entry sends nothing", 64'(lg_n - base), 64'd0);
    bus_rd(1, 0, 8, r);
    chk("R7 pending bit 2", r, 64'h04);

    // R9 entry unmask replays
    bus_wr(0, 2 * 16 + 12, 4, 64'd0);
    idle(4);
    chk("R9 replay count", 64'(lg_n - base), 64'd1);
    chk_msg("R9", base, 2);
    bus_rd(1, 0, 8, r);
    chk("R9 pending cleared", r, 64'd0);

    // R7 read-only pending region, half-word reads
    bus_wr(0, 5 * 16 + 12, 4, 64'd1);
    pulse(8'h20);
    idle(2);
    bus_wr(1, 0, 8, 64'd0);
    bus_rd(1, 0, 8, r);
    chk("R7 pending write ignored", r, 64'h20);
    bus_rd(1, 4, 4, r);
    chk("R7 upper half", r, 64'd0);
    bus_rd(1, 0, 4, r);
    chk("R7 lower half", r, 64'h20);
    base = lg_n;
    bus_wr(0, 5 * 16 + 12, 4, 64'd0);
    idle(4);
    chk_msg("R9 vec5", base, 5);

    // R8 / R10 function mask replay, stalled consumer
    ctl_wr(16'hC000);
    base = lg_n;
    pulse('1);
    idle(3);
    chk("R7 function mask sends nothing", 64'(lg_n - base), 64'd0);
    bus_rd(1, 0, 8, r);
    chk("R7 all pending", r, 64'hFF);
    bus_wr(0, 4 * 16 + 12, 4, 64'd1);
    msg_ready = 1'b0;
    ctl_wr(16'h8000);
    idle(5);
    bus_rd(1, 0, 8, r);
    chk("R10 pending held while stalled", r, 64'hFF);
    chk("R10 offer while stalled", 64'(msg_valid), 64'd1);
    @(negedge clk);
    msg_ready = 1'b1;
    idle(12);
    chk("R8 replay count", 64'(lg_n - base), 64'd7);
    k = 0;
    for (int e = 0; e < NV; e++) begin
      if (e != 4) begin
        chk_msg("R10 order", base + k, e);
        k++;
      end
    end
    bus_rd(1, 0, 8, r);
    chk("R8 only masked entry left", r, 64'h10);
    base = lg_n;
    bus_wr(0, 4 * 16 + 12, 4, 64'd0);
    idle(4);
    chk_msg("R9 vec4", base, 4);

    // R12 withdrawn when masked before acceptance
    msg_ready = 1'b0;
    base = lg_n;
    pulse(8'h40);
    idle(2);
    chk("R12 offered", 64'(msg_valid), 64'd1);
    bus_wr(0, 6 * 16 + 12, 4, 64'd1);
    @(negedge clk);
    msg_ready = 1'b1;
    idle(4);
    chk("R12 nothing sent", 64'(lg_n - base), 64'd0);
    bus_rd(1, 0, 8, r);
    chk("R12 moved to pending", r, 64'h40);
    bus_wr(0, 6 * 16 + 12, 4, 64'd0);
    idle(4);
    chk_msg("R12 replay", base, 6);

    // R11 disable again: requests ignored, no state change
    ctl_wr(16'h0000);
    base = lg_n;
    pulse('1);
    idle(4);
    chk("R11 disabled no message", 64'(lg_n - base), 64'd0);
    bus_rd(1, 0, 8, r);
    chk("R11 disabled no pending", r, 64'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule